// File: doc/BRIEF.md
# Addition-Chain Binary Field Inverter

This block computes the multiplicative inverse of an element of GF(2^M) in polynomial basis. It raises the operand to the power 2^M−2 without any division. Along the way it builds terms of the form a^(2^k−1). Two such terms of orders i and j combine into the term of order i+j: the first term is raised to 2^j, then multiplied by the second. The controller walks an addition chain for M−1 taken from the binary expansion of M−1. Each chain step either doubles k or adds one to it. When the chain reaches k = M−1, the term is squared once more, which gives a^(2^M−2) = a^(-1).

The datapath holds one combinational field multiplier and one power block. The power block is a cascade of STAGES circuits, and each circuit raises its input to 2^POW_N. It has a tap after every squaring, so a single cycle can apply any number of squarings from 1 to STAGES·POW_N. On each cycle the controller enables at most one of the two units. The product is kept in a multiplier-output register, and a second storage register holds the chain term that the next doubling step multiplies by.

A user pulses `start` with the operand on `a_in` while `busy` is low. The block then raises `busy`. When the inverse is ready it drops `busy`, presents the result and pulses `done`.

Top module: `gf2m_inverter`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` sampled high while `busy` is low is accepted: `busy` is high from the next cycle until the operation ends.
- R3: For every nonzero `a_in`, the `result` of the operation satisfies a_in · result = 1 in GF(2^M). Field elements are M-bit vectors in which bit i is the coefficient of x^i. The reduction polynomial is x^M plus the polynomial whose coefficient bits are given by parameter POLY (default M=8, POLY=8'h1B, that is x^8+x^4+x^3+x+1).
- R4: An `a_in` of 0 yields a `result` of 0.
- R5: `done` is high for exactly one cycle per accepted operation, and in that cycle `busy` is already low.
- R6: `result` changes only in a cycle where `done` is high, and it then holds until the next `done`.
- R7: The multiplier and the power block are never active in the same cycle. A chain step that raises by 2^k takes ceil(k/(STAGES·POW_N)) power cycles and then one multiply cycle. Measured from the clock edge that accepts `start`, `done` is high after exactly S+1 edges, where S is the sum of those step cycles over the chain. With the defaults (M=8, quad stages, two stages) this is 9 edges. With one squaring per cycle it is 11 edges.
- R8: A `start` pulse while `busy` is high is ignored. The running operation completes with the inverse of the operand it accepted, and no further operation follows.
- R9: A `start` given in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an inversion of `a_in` (accepted only when not busy) |
| a_in | input | M | Operand, polynomial basis |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | M | Inverse of the last accepted operand |

## Verification
On every cycle, the assertions check the handshake: start acceptance, the single-cycle `done` with `busy` already low, `result` changing only on `done`, and a zero operand giving a zero result. They also check that the multiplier and power block enables are never high together, and that the busy interval stays within a bound. Only the bench scenarios can show that the value is truly the field inverse for every nonzero element. The same holds for the exact cycle count of the addition chain under two power-block configurations, for a `start` during an operation having no effect, and for back-to-back operations.

// File: rtl/gf2m_inv_pkg.sv
`timescale 1ns/1ps
package gf2m_inv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POW  = 2'd1,
    ST_MUL  = 2'd2,
    ST_FIN  = 2'd3
  } inv_state_e;
endpackage

// File: rtl/gf2m_inv_mult.sv
`timescale 1ns/1ps
// Combinational GF(2^M) multiplier: carry-less product then reduction.
module gf2m_inv_mult #(
  parameter int          M    = 8,
  parameter logic [M-1:0] POLY = 8'h1B
) (
  input  logic [M-1:0] x,
  input  logic [M-1:0] y,
  output logic [M-1:0] z
);
  localparam int PW = 2*M - 1;

  logic [PW-1:0] prod;

  always_comb begin
    prod = '0;
    for (int i = 0; i < M; i++) begin
      if (y[i]) prod = prod ^ (PW'(x) << i);
    end
    for (int i = PW-1; i >= M; i--) begin
      if (prod[i]) begin
        prod[i] = 1'b0;
        prod    = prod ^ (PW'(POLY) << (i - M));
      end
    end
    z = prod[M-1:0];
  end
endmodule

// File: rtl/gf2m_inv_sqr.sv
`timescale 1ns/1ps
// Combinational squarer: bit spreading followed by reduction.
module gf2m_inv_sqr #(
  parameter int          M    = 8,
  parameter logic [M-1:0] POLY = 8'h1B
) (
  input  logic [M-1:0] x,
  output logic [M-1:0] z
);
  localparam int PW = 2*M - 1;

  logic [PW-1:0] sp;

  always_comb begin
    sp = '0;
    for (int i = 0; i < M; i++) sp[2*i] = x[i];
    for (int i = PW-1; i >= M; i--) begin
      if (sp[i]) begin
        sp[i] = 1'b0;
        sp    = sp ^ (PW'(POLY) << (i - M));
      end
    end
    z = sp[M-1:0];
  end
endmodule

// File: rtl/gf2m_inv_powblk.sv
`timescale 1ns/1ps
// Cascade of STAGES circuits, each raising to 2^POW_N, tapped after
// every squaring so one pass can apply 1..STAGES*POW_N squarings.
module gf2m_inv_powblk #(
  parameter int          M      = 8,
  parameter logic [M-1:0] POLY   = 8'h1B,
  parameter int          POW_N  = 2,
  parameter int          STAGES = 2,
  localparam int         SQMAX  = POW_N * STAGES,
  localparam int         SW     = $clog2(SQMAX + 1)
) (
  input  logic [M-1:0]  din,
  input  logic [SW-1:0] cnt,
  output logic [M-1:0]  dout
);
  logic [SQMAX:0][M-1:0] tap;

  assign tap[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar q = 0; q < POW_N; q++) begin : g_sq
      gf2m_inv_sqr #(.M(M), .POLY(POLY)) u_sq (
        .x(tap[s*POW_N + q]),
        .z(tap[s*POW_N + q + 1])
      );
    end
  end

  always_comb begin
    dout = din;
    for (int i = 1; i <= SQMAX; i++) begin
      if (cnt == SW'(i)) dout = tap[i];
    end
  end
endmodule

// File: rtl/gf2m_inv_ctrl.sv
`timescale 1ns/1ps
// Chain sequencer: walks the bits of M-1 below its leading one.
// Each bit is a doubling step, plus an add-one step when the bit is set.
module gf2m_inv_ctrl
  import gf2m_inv_pkg::*;
#(
  parameter int M     = 8,
  parameter int SQMAX = 4,
  localparam int SW   = $clog2(SQMAX + 1),
  localparam int KW   = $clog2(M),
  localparam int EB   = $clog2(M),
  localparam int BW   = $clog2(EB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load_op,
  output logic          keep_ld,
  output logic          pow_en,
  output logic          pow_from_mout,
  output logic [SW-1:0] pow_cnt,
  output logic          mul_en,
  output logic          mul_with_op,
  output logic          fin,
  output logic          busy,
  output logic          done
);
  localparam logic [KW-1:0] EVEC = KW'(M - 1);

  inv_state_e    st_q, st_d;
  logic [KW-1:0] k_q, k_d, rem_q, rem_d, kn;
  logic [BW-1:0] bpos_q, bpos_d;
  logic          plus_q, plus_d, first_q, first_d;
  logic          ebit;
  logic [SW-1:0] step_cnt;
  logic          busy_q, done_q;

  always_comb begin
    ebit = 1'b0;
    for (int i = 0; i < KW; i++) begin
      if (bpos_q == BW'(i + 1)) ebit = EVEC[i];
    end
  end

  always_comb begin
    if (int'(rem_q) > SQMAX) step_cnt = SW'(SQMAX);
    else                     step_cnt = SW'(rem_q);
  end

  always_comb begin
    st_d          = st_q;
    k_d           = k_q;
    rem_d         = rem_q;
    bpos_d        = bpos_q;
    plus_d        = plus_q;
    first_d       = first_q;
    kn            = k_q;
    load_op       = 1'b0;
    keep_ld       = 1'b0;
    pow_en        = 1'b0;
    pow_from_mout = first_q;
    pow_cnt       = step_cnt;
    mul_en        = 1'b0;
    mul_with_op   = plus_q;
    fin           = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load_op = 1'b1;
          k_d     = KW'(1);
          rem_d   = KW'(1);
          bpos_d  = BW'(EB - 1);
          plus_d  = 1'b0;
          first_d = 1'b1;
          st_d    = (EB > 1) ? ST_POW : ST_FIN;
        end
      end
      ST_POW: begin
        pow_en  = 1'b1;
        rem_d   = rem_q - KW'(step_cnt);
        first_d = 1'b0;
        if (int'(rem_q) <= SQMAX) st_d = ST_MUL;
      end
      ST_MUL: begin
        mul_en  = 1'b1;
        first_d = 1'b1;
        if (!plus_q && ebit) begin
          k_d    = k_q << 1;
          plus_d = 1'b1;
          rem_d  = KW'(1);
          st_d   = ST_POW;
        end else begin
          kn     = plus_q ? (k_q + KW'(1)) : (k_q << 1);
          k_d    = kn;
          rem_d  = kn;
          plus_d = 1'b0;
          bpos_d = bpos_q - BW'(1);
          if (bpos_q > BW'(1)) begin
            keep_ld = 1'b1;
            st_d    = ST_POW;
          end else begin
            st_d    = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        pow_en        = 1'b1;
        pow_from_mout = 1'b1;
        pow_cnt       = SW'(1);
        fin           = 1'b1;
        st_d          = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      k_q     <= '0;
      rem_q   <= '0;
      bpos_q  <= '0;
      plus_q  <= 1'b0;
      first_q <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      k_q     <= k_d;
      rem_q   <= rem_d;
      bpos_q  <= bpos_d;
      plus_q  <= plus_d;
      first_q <= first_d;
      busy_q  <= (st_d != ST_IDLE);
      done_q  <= fin;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/gf2m_inverter.sv
`timescale 1ns/1ps
module gf2m_inverter #(
  parameter int          M      = 8,
  parameter logic [M-1:0] POLY   = 8'h1B,
  parameter int          POW_N  = 2,
  parameter int          STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a_in,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] result
);
  localparam int SQMAX = POW_N * STAGES;
  localparam int SW    = $clog2(SQMAX + 1);

  logic          load_op, keep_ld, pow_en, pow_from_mout, mul_en, mul_with_op, fin;
  logic [SW-1:0] pow_cnt;
  logic [M-1:0]  a_q, mout_q, pw_q, keep_q, res_q;
  logic [M-1:0]  pow_din, pow_dout, mul_y, mul_z;

  gf2m_inv_ctrl #(.M(M), .SQMAX(SQMAX)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load_op(load_op), .keep_ld(keep_ld),
    .pow_en(pow_en), .pow_from_mout(pow_from_mout), .pow_cnt(pow_cnt),
    .mul_en(mul_en), .mul_with_op(mul_with_op), .fin(fin),
    .busy(busy), .done(done)
  );

  assign pow_din = pow_from_mout ? mout_q : pw_q;
  assign mul_y   = mul_with_op ? a_q : keep_q;

  gf2m_inv_powblk #(.M(M), .POLY(POLY), .POW_N(POW_N), .STAGES(STAGES)) u_pow (
    .din(pow_din), .cnt(pow_cnt), .dout(pow_dout)
  );

  gf2m_inv_mult #(.M(M), .POLY(POLY)) u_mul (
    .x(pw_q), .y(mul_y), .z(mul_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      mout_q <= '0;
      pw_q   <= '0;
      keep_q <= '0;
      res_q  <= '0;
    end else begin
      if (load_op) begin
        a_q    <= a_in;
        mout_q <= a_in;
        keep_q <= a_in;
      end
      if (pow_en && !fin) pw_q <= pow_dout;
      if (mul_en) mout_q <= mul_z;
      if (keep_ld) keep_q <= mul_z;
      if (fin) res_q <= pow_dout;
    end
  end

  assign result = res_q;
endmodule

// File: rtl/gf2m_inverter_chk.sv
`timescale 1ns/1ps
module gf2m_inverter_chk #(
  parameter int M   = 8,
  parameter int LIM = 72
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] result,
  input logic [M-1:0] a_q,
  input logic         mul_en,
  input logic         pow_en
);
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 32'd1;
    else           bcnt <= '0;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done && result == '0));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (done && a_q == '0) |-> (result == '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_res_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);

  p_one_unit_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mul_en, pow_en}));

  p_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt <= LIM));

  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(a_q));
endmodule

bind gf2m_inverter gf2m_inverter_chk #(.M(M), .LIM(M*M + 8)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .result(result), .a_q(a_q), .mul_en(mul_en), .pow_en(pow_en)
);

// File: tb/gf2m_inverter_bench.sv
`timescale 1ns/1ps
module gf2m_inverter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       st0 = 1'b0, st1 = 1'b0;
  logic [7:0] a0 = '0, a1 = '0;
  logic       bz0, bz1, dn0, dn1;
  logic [7:0] r0, r1;
  int         checks = 0;
  int         failures = 0;

  always #2.5 clk = ~clk;

  gf2m_inverter #(.M(8), .POLY(8'h1B), .POW_N(2), .STAGES(2)) u_gf2m_inverter (
    .clk(clk), .rst(rst), .start(st0), .a_in(a0),
    .busy(bz0), .done(dn0), .result(r0)
  );

  gf2m_inverter #(.M(8), .POLY(8'h1B), .POW_N(1), .STAGES(1)) u_gf2m_inverter_sq (
    .clk(clk), .rst(rst), .start(st1), .a_in(a1),
    .busy(bz1), .done(dn1), .result(r1)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc = 8'h00;
    logic [7:0] t = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ t;
      t = t[7] ? (8'(t << 1) ^ 8'h1B) : 8'(t << 1);
    end
    return acc;
  endfunction

  function automatic int exp_lat(input int m, input int sqmax);
    int e = m - 1;
    int nb = 0;
    int k = 1;
    int s = 0;
    for (int t = e; t > 0; t = t >> 1) nb++;
    for (int i = nb - 2; i >= 0; i--) begin
      s = s + (k + sqmax - 1) / sqmax + 1;
      k = 2 * k;
      if (((e >> i) & 1) == 1) begin
        s = s + 2;
        k = k + 1;
      end
    end
    return s + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge where done is seen.
  task automatic run_op(input int which, input logic [7:0] av, input bit intr,
                        input logic [7:0] bv, output logic [7:0] res,
                        output int lat);
    bit d;
    if (which == 0) begin st0 = 1'b1; a0 = av; end
    else            begin st1 = 1'b1; a1 = av; end
    @(posedge clk);
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1) begin
        st0 = 1'b0; st1 = 1'b0;
        chk((which == 0 ? bz0 : bz1) == 1'b1, "R2", "busy after start",
            int'(which == 0 ? bz0 : bz1), 1);
      end
      if (intr && lat == 2) begin
        if (which == 0) begin st0 = 1'b1; a0 = bv; end
        else            begin st1 = 1'b1; a1 = bv; end
      end
      if (intr && lat == 3) begin st0 = 1'b0; st1 = 1'b0; end
      d = (which == 0) ? dn0 : dn1;
      if (d) break;
      if (lat > 500) begin
        chk(1'b0, "R7", "operation never finished", lat, 0);
        break;
      end
    end
    res = (which == 0) ? r0 : r1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bz0 == 1'b0, "R1", "busy in reset", int'(bz0), 0);
    chk(dn0 == 1'b0, "R1", "done in reset", int'(dn0), 0);
    chk(r0 == 8'h00, "R1", "result in reset", int'(r0), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bz0 == 1'b0 && dn0 == 1'b0 && r0 == 8'h00, "R1", "state after reset",
        int'({bz0, dn0, r0}), 0);
  endtask

  task automatic t_all_elements;
    logic [7:0] res;
    int lat;
    for (int v = 1; v < 256; v++) begin
      run_op(0, 8'(v), 1'b0, 8'h00, res, lat);
      chk(ref_mul(8'(v), res) == 8'h01, "R3", $sformatf("a*inv(a) for a=%0h", v),
          int'(ref_mul(8'(v), res)), 1);
      if (v == 1 || v == 255)
        chk(lat == exp_lat(8, 4), "R7", "latency with quad stages", lat, exp_lat(8, 4));
      @(negedge clk);
    end
  endtask

  task automatic t_zero;
    logic [7:0] res;
    int lat;
    run_op(0, 8'h00, 1'b0, 8'h00, res, lat);
    chk(res == 8'h00, "R4", "inverse of zero", int'(res), 0);
    @(negedge clk);
  endtask

  task automatic t_pulse_and_hold;
    logic [7:0] res;
    int lat;
    run_op(0, 8'h53, 1'b0, 8'h00, res, lat);
    chk(bz0 == 1'b0, "R5", "busy low with done", int'(bz0), 0);
    @(negedge clk);
    chk(dn0 == 1'b0, "R5", "done lasts one cycle", int'(dn0), 0);
    for (int i = 0; i < 20; i++) begin
      a0 = 8'(i * 7 + 3);
      @(negedge clk);
      chk(r0 == res && dn0 == 1'b0, "R6", "result held while idle", int'(r0), int'(res));
    end
  endtask

  task automatic t_busy_ignore;
    logic [7:0] res;
    int lat;
    run_op(0, 8'h02, 1'b1, 8'hCA, res, lat);
    chk(ref_mul(8'h02, res) == 8'h01, "R8", "start while busy ignored",
        int'(ref_mul(8'h02, res)), 1);
    chk(lat == exp_lat(8, 4), "R8", "latency unchanged by ignored start", lat, exp_lat(8, 4));
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk(bz0 == 1'b0 && dn0 == 1'b0, "R8", "no second operation started",
          int'({bz0, dn0}), 0);
    end
  endtask

  task automatic t_back_to_back;
    logic [7:0] res1, res2;
    int lat1, lat2;
    run_op(0, 8'h11, 1'b0, 8'h00, res1, lat1);
    run_op(0, 8'hE5, 1'b0, 8'h00, res2, lat2);
    chk(ref_mul(8'h11, res1) == 8'h01, "R9", "first of pair", int'(ref_mul(8'h11, res1)), 1);
    chk(ref_mul(8'hE5, res2) == 8'h01, "R9", "second of pair", int'(ref_mul(8'hE5, res2)), 1);
    chk(lat2 == exp_lat(8, 4), "R9", "second started in done cycle", lat2, exp_lat(8, 4));
    @(negedge clk);
  endtask

  task automatic t_single_square;
    logic [7:0] res;
    int lat;
    for (int v = 1; v < 256; v = v * 3 + 1) begin
      run_op(1, 8'(v), 1'b0, 8'h00, res, lat);
      chk(ref_mul(8'(v), res) == 8'h01, "R3", "one squaring per cycle inverse",
          int'(ref_mul(8'(v), res)), 1);
      chk(lat == exp_lat(8, 1), "R7", "latency with one squaring per cycle",
          lat, exp_lat(8, 1));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_all_elements();
    t_zero();
    t_pulse_and_hold();
    t_busy_ignore();
    t_back_to_back();
    t_single_square();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule